// File: doc/BRIEF.md
# Serial Single-Error-Correcting Cyclic Code Decoder

This block receives a serial stream of cyclic-code words of length N = 2^M - 1, built from a primitive generator of degree M. By default M = 3, which gives the 7-bit, 4-data-bit code with generator x^3 + x + 1. The block returns each word with any single bit error repaired. Bits arrive one per accepted cycle, highest polynomial position first. Each bit enters a capture buffer and a three-stage division register at the same time. When the last bit of a word arrives, the remainder of the word divided by the generator is the syndrome. Because the generator is primitive, a single error at position j leaves the syndrome equal to alpha^j in polynomial basis.

On that same cycle, the captured word moves to a readout buffer and the syndrome is loaded into a locator register. During readout the locator register multiplies itself by alpha on each clock. A NOR over the XOR of the register and a fixed target pattern raises a pointer in exactly the cycle that the erroneous position is presented, and the pointer inverts that bit. No table lookup is used. The corrected word streams out serially. When readout ends, the data part is also given in parallel, together with a flag that reports a nonzero syndrome. A new word can be shifted in while the previous one is read out.

Top module: `bch_serial_decoder`

## Requirements
- R1: A bit is taken only in cycles with `in_valid` high. The first bit taken is polynomial position N-1. A word is complete after N taken bits, and cycles with `in_valid` low may fall anywhere between the bits of a word without changing the result.
- R2: A received word whose remainder modulo the generator is zero is passed through unchanged, and its `err_flag` is 0.
- R3: A word with exactly one inverted bit, at any of the N positions, is delivered as the original codeword, and its `err_flag` is 1.
- R4: Serial output starts in the cycle after the clock edge that takes the last input bit. `out_valid` is then high for N consecutive cycles, and the bits come out from position N-1 down to position 0.
- R5: At most one bit of a word is inverted during readout.
- R6: `msg_valid` is a one-cycle pulse in the cycle after the last serial output bit. `msg` then holds corrected positions N-1 down to M, with position N-1 in bit K-1. `err_flag` belongs to the same word and holds until the next pulse.
- R7: While `rst_n` is low, `out_valid`, `msg_valid`, `err_flag` and `msg` are 0. A partly received word is discarded, and the next N taken bits form a fresh word.
- R8: Words may arrive back to back with no idle cycle, and every complete word yields exactly one `msg_valid` pulse.
- R9: A word with two inverted bits has a nonzero syndrome. It is reported with `err_flag` 1 and no other failure indication, and the decoder inverts the single position named by the syndrome. For example, codeword 0000000 received as 0000011 is delivered as 0001011, with data 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Serial received bit, highest position first |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | Serial corrected bit, highest position first |
| msg_valid | output | 1 | One-cycle pulse: `msg` and `err_flag` are valid |
| msg | output | K (4) | Corrected data positions N-1..M |
| err_flag | output | 1 | Syndrome of the word in `msg` was nonzero |

## Verification
The bench feeds every data value with no error and with each single-bit error. A locator whose start value or target pattern is off by one power of alpha would repair the wrong neighbour, and this sweep catches it. A remainder register that still holds bits from the previous word would fail on the back-to-back words. Gapped input is sent to catch a buffer that shifts on idle cycles. A double error is sent to confirm the exact miscorrection. The bench checks the first output cycle and the timing of the `msg_valid` pulse. A reset in the middle of a word must leave no trace of the stale bits.

// File: rtl/bch_dec_pkg.sv
package bch_dec_pkg;

   // How the locator register is primed at the end of a word.
   typedef enum logic {
      LOC_PRESTEP = 1'b0,   // load syndrome*alpha, look for the unit element
      LOC_DIRECT  = 1'b1    // load syndrome, look for alpha^(N-1)
   } loc_mode_e;

   localparam int unsigned GF_M_MIN = 3;
   localparam int unsigned GF_M_MAX = 15;

endpackage

// File: rtl/bch_syn_div.sv
module bch_syn_div #(
   parameter int unsigned M    = 3,
   parameter logic [M:0]  POLY = 4'b1011
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_bit,
   input  logic         clear,
   output logic [M-1:0] rem
);

   logic [M-1:0] part;

   function automatic logic [M-1:0] mul_x(input logic [M-1:0] v);
      mul_x = {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY[M-1:0] : '0);
   endfunction

   // remainder including the bit presented this cycle
   assign rem = mul_x(part) ^ {{(M-1){1'b0}}, in_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part <= '0;
      end else if (in_valid) begin
         part <= clear ? '0 : rem;
      end
   end

endmodule

// File: rtl/bch_chien_search.sv
module bch_chien_search
   import bch_dec_pkg::*;
#(
   parameter int unsigned M    = 3,
   parameter logic [M:0]  POLY = 4'b1011,
   parameter loc_mode_e   MODE = LOC_PRESTEP
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [M-1:0] syn_in,
   input  logic         step,
   input  logic         done,
   output logic         ptr
);

   localparam int unsigned N      = (1 << M) - 1;
   localparam logic [M-1:0] GF_ONE = M'(1);

   function automatic logic [M-1:0] mul_x(input logic [M-1:0] v);
      mul_x = {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY[M-1:0] : '0);
   endfunction

   function automatic logic [M-1:0] pow_alpha(input int unsigned e);
      logic [M-1:0] r;
      r = GF_ONE;
      for (int unsigned i = 0; i < e; i++) r = mul_x(r);
      return r;
   endfunction

   logic [M-1:0] load_val;
   logic [M-1:0] target;
   logic [M-1:0] loc;
   logic         hit;

   generate
      if (MODE == LOC_PRESTEP) begin : g_prestep
         assign load_val = mul_x(syn_in);
         assign target   = GF_ONE;
      end else begin : g_direct
         localparam logic [M-1:0] LAST_POW = pow_alpha(N - 1);
         assign load_val = syn_in;
         assign target   = LAST_POW;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc <= '0;
      end else if (load) begin
         loc <= load_val;
      end else if (step) begin
         loc <= mul_x(loc);
      end
   end

   // zero-pattern detector: NOR over the difference from the target
   assign hit = ~|(loc ^ target);
   assign ptr = step & hit;

   // per-word bookkeeping used only by the assertions below
   logic fired;
   logic nz;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired <= 1'b0;
         nz    <= 1'b0;
      end else if (load) begin
         fired <= 1'b0;
         nz    <= |syn_in;
      end else if (ptr) begin
         fired <= 1'b1;
      end
   end

   // R5: the pointer fires at most once per word
   a_r5_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      ptr |-> !fired);

   // R3: a nonzero syndrome always names a position inside the word
   a_r3_error_located: assert property (@(posedge clk) disable iff (!rst_n)
      (done && nz) |-> (fired || ptr));

endmodule

// File: rtl/bch_word_store.sv
module bch_word_store #(
   parameter int unsigned N = 7,
   parameter int unsigned K = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_bit,
   input  logic         flip,
   output logic         load,
   output logic         out_valid,
   output logic         out_bit,
   output logic         last_step,
   output logic         msg_valid,
   output logic [K-1:0] msg
);

   localparam int unsigned   CW       = $clog2(N);
   localparam logic [CW-1:0] CNT_LAST = CW'(N - 1);
   localparam logic [CW-1:0] CNT_DATA = CW'(K);

   logic [N-2:0]  cap_buf;
   logic [CW-1:0] cap_cnt;
   logic [N-1:0]  rd_word;
   logic [CW-1:0] rd_cnt;
   logic          rd_act;
   logic [K-1:0]  data_sr;

   assign load      = in_valid && (cap_cnt == CNT_LAST);
   assign last_step = rd_act && (rd_cnt == CNT_LAST);
   assign out_valid = rd_act;
   assign out_bit   = rd_word[N-1] ^ (flip & rd_act);
   assign msg       = data_sr;

   // capture side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_buf <= '0;
         cap_cnt <= '0;
      end else if (in_valid) begin
         cap_buf <= {cap_buf[N-3:0], in_bit};
         cap_cnt <= load ? '0 : cap_cnt + 1'b1;
      end
   end

   // readout side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_word <= '0;
         rd_cnt  <= '0;
         rd_act  <= 1'b0;
      end else if (load) begin
         rd_word <= {cap_buf, in_bit};
         rd_cnt  <= '0;
         rd_act  <= 1'b1;
      end else if (rd_act) begin
         rd_word <= {rd_word[N-2:0], 1'b0};
         rd_cnt  <= rd_cnt + 1'b1;
         if (rd_cnt == CNT_LAST) rd_act <= 1'b0;
      end
   end

   // data collection and completion pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_sr   <= '0;
         msg_valid <= 1'b0;
      end else begin
         if (rd_act && (rd_cnt < CNT_DATA)) data_sr <= {data_sr[K-2:0], out_bit};
         msg_valid <= last_step;
      end
   end

   // R6: completion is a single-cycle pulse
   a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);

   // R4: the readout run ends exactly where the pulse starts
   a_r4_run_then_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_act) |-> msg_valid);

   // R8: a new word only lands as the previous readout finishes
   a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (load && rd_act) |-> last_step);

endmodule

// File: rtl/bch_serial_decoder.sv
module bch_serial_decoder
   import bch_dec_pkg::*;
#(
   parameter int unsigned M    = 3,
   parameter logic [M:0]  POLY = 4'b1011,
   parameter loc_mode_e   MODE = LOC_PRESTEP,
   localparam int unsigned N   = (1 << M) - 1,
   localparam int unsigned K   = N - M
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_bit,
   output logic         out_valid,
   output logic         out_bit,
   output logic         msg_valid,
   output logic [K-1:0] msg,
   output logic         err_flag
);

   generate
      if (M < GF_M_MIN || M > GF_M_MAX) begin : g_bad_m
         $error("field degree out of supported range");
      end
      if (!POLY[M] || !POLY[0]) begin : g_bad_poly
         $error("generator must have degree M and a nonzero constant term");
      end
   endgenerate

   logic         load;
   logic         last_step;
   logic         flip;
   logic [M-1:0] rem;
   logic         rd_err;

   bch_syn_div #(.M(M), .POLY(POLY)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .clear    (load),
      .rem      (rem)
   );

   bch_word_store #(.N(N), .K(K)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .flip      (flip),
      .load      (load),
      .out_valid (out_valid),
      .out_bit   (out_bit),
      .last_step (last_step),
      .msg_valid (msg_valid),
      .msg       (msg)
   );

   bch_chien_search #(.M(M), .POLY(POLY), .MODE(MODE)) u_loc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .syn_in (rem),
      .step   (out_valid),
      .done   (last_step),
      .ptr    (flip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_err   <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (load)      rd_err   <= |rem;
         if (last_step) err_flag <= rd_err;
      end
   end

   // R2: a clean word is never altered
   a_r2_clean_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !rd_err) |-> !flip);

   // R1: output never starts without an accepted input bit
   a_r1_no_spurious_output: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !out_valid) |=> !out_valid);

endmodule

// File: tb/bch_serial_decoder_test.sv
module bch_serial_decoder_test;

   localparam int N = 7;
   localparam int K = 4;

   // {data, codeword} for every data value, generator x^3+x+1, data at positions 6..3
   localparam logic [10:0] CODE_TAB [16] = '{
      {4'h0, 7'h00}, {4'h1, 7'h0B}, {4'h2, 7'h16}, {4'h3, 7'h1D},
      {4'h4, 7'h27}, {4'h5, 7'h2C}, {4'h6, 7'h31}, {4'h7, 7'h3A},
      {4'h8, 7'h45}, {4'h9, 7'h4E}, {4'hA, 7'h53}, {4'hB, 7'h58},
      {4'hC, 7'h62}, {4'hD, 7'h69}, {4'hE, 7'h74}, {4'hF, 7'h7F}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic out_valid, out_bit, msg_valid, err_flag;
   logic [K-1:0] msg;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [K-1:0] exp_msg [256];
   logic         exp_err [256];
   logic [N-1:0] exp_ser [256];
   string        exp_tag [256];
   int enq = 0;
   int widx = 0;
   logic [N-1:0] ser = '0;

   always #4 clk = ~clk;   // 125 MHz

   bch_serial_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
      .out_valid(out_valid), .out_bit(out_bit), .msg_valid(msg_valid),
      .msg(msg), .err_flag(err_flag)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // monitor: compares every completed word with its expectation
   always @(negedge clk) begin
      if (rst_n) begin
         if (msg_valid) begin
            if (widx < enq) begin
               check(msg == exp_msg[widx], exp_tag[widx], "msg", int'(msg), int'(exp_msg[widx]));
               check(err_flag == exp_err[widx], exp_tag[widx], "err_flag",
                     int'(err_flag), int'(exp_err[widx]));
               check(ser == exp_ser[widx], "R4", "serial word", int'(ser), int'(exp_ser[widx]));
            end else begin
               check(1'b0, "R8", "unexpected msg_valid", widx, enq);
            end
            widx++;
         end
         if (out_valid) ser = {ser[N-2:0], out_bit};
      end
   end

   task automatic send_word(input logic [N-1:0] word, input logic [K-1:0] emsg,
                            input logic eerr, input logic [N-1:0] eser,
                            input string tag, input int gap);
      exp_msg[enq] = emsg;
      exp_err[enq] = eerr;
      exp_ser[enq] = eser;
      exp_tag[enq] = tag;
      enq++;
      for (int b = N - 1; b >= 0; b--) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_bit   = word[b];
         if (gap > 0 && b > 0) begin
            repeat (gap) begin
               @(posedge clk); #1;
               in_valid = 1'b0;
               in_bit   = 1'b1;
            end
         end
      end
   endtask

   task automatic idle(input int n);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_bit   = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         failures++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] w;
      // reset state (R7)
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
      check(msg_valid == 1'b0, "R7", "msg_valid in reset", int'(msg_valid), 0);
      check(err_flag == 1'b0, "R7", "err_flag in reset", int'(err_flag), 0);
      check(msg == '0, "R7", "msg in reset", int'(msg), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // table sweep: every data value, clean and each single error, back to back (R2, R3, R8)
      for (int mi = 0; mi < 16; mi++) begin
         for (int ei = -1; ei < N; ei++) begin
            w = CODE_TAB[mi][6:0];
            if (ei >= 0) w[ei] = ~w[ei];
            send_word(w, CODE_TAB[mi][10:7], ei >= 0, CODE_TAB[mi][6:0],
                      (ei < 0) ? "R2" : "R3", 0);
         end
      end
      idle(12);

      // gapped input (R1): data A, error at position 2
      send_word(7'h57, 4'hA, 1'b1, 7'h53, "R1", 2);
      idle(12);

      // double error (R9): zero codeword with positions 0 and 1 inverted
      send_word(7'h03, 4'h1, 1'b1, 7'h0B, "R9", 0);
      idle(12);

      // output timing (R4, R6): data D, error at position 0
      send_word(7'h68, 4'hD, 1'b1, 7'h69, "R6", 0);
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b1, "R4", "out_valid after last bit", int'(out_valid), 1);
      check(out_bit == 1'b1, "R4", "first serial bit", int'(out_bit), 1);
      for (int i = 1; i < N; i++) begin
         @(negedge clk);
         check(out_valid == 1'b1, "R4", "out_valid during run", int'(out_valid), 1);
         check(msg_valid == 1'b0, "R6", "msg_valid early", int'(msg_valid), 0);
      end
      @(negedge clk);
      check(out_valid == 1'b0, "R4", "out_valid after run", int'(out_valid), 0);
      check(msg_valid == 1'b1, "R6", "msg_valid position", int'(msg_valid), 1);
      @(negedge clk);
      check(msg_valid == 1'b0, "R6", "msg_valid width", int'(msg_valid), 0);
      check(err_flag == 1'b1, "R6", "err_flag hold", int'(err_flag), 1);
      idle(12);

      // reset in the middle of a word (R7)
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_bit   = 1'b1;
      end
      @(posedge clk); #1;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check(msg == '0, "R7", "msg cleared", int'(msg), 0);
      check(err_flag == 1'b0, "R7", "err_flag cleared", int'(err_flag), 0);
      check(out_valid == 1'b0, "R7", "out_valid cleared", int'(out_valid), 0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      send_word(7'h05, 4'h8, 1'b1, 7'h45, "R7", 0);
      idle(12);

      check(widx == enq, "R8", "word count", widx, enq);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule